// File: doc/BRIEF.md
# Stepped Sawtooth Channel

This block makes a stepped sawtooth waveform for a sound channel. An 8-bit accumulator adds a programmable rate on every step. Every seventh step, it starts again from zero. The upper five bits of the accumulator form the channel level.

A period timer sets the step rate. The timer runs from a caller-supplied clock enable. It is divided by two first, so one step lasts twice the programmed 12-bit period. Software programs the channel through three byte-wide registers behind a 2-bit address:

| Address | Bits | Meaning |
|---|---|---|
| 0 | [5:0] | Rate |
| 1 | [7:0] | Period, low byte |
| 2 | [3:0] | Period, high nibble |
| 2 | [7] | Enable |

Clearing the enable bit freezes the waveform. While the channel is disabled, the level shows the accumulator directly.

Top module: `saw_channel`

## Requirements
- R1: After a synchronous active-low reset, `level` is 0, the accumulator is 0 and the step counter is 1. The first step therefore outputs 0 and clears the accumulator.
- R2: Register writes (`wr_en`) take effect on the next clock edge.
  - Address 0 sets the rate from `wr_data[5:0]`; bits 7:6 are ignored.
  - Address 1 sets period bits 7:0.
  - Address 2 sets period bits 11:8 from `wr_data[3:0]` and sets enable from `wr_data[7]`.
  - A write to address 3 changes nothing.
- R3: A prescaler halves the `tick_en` rate. With period P ≥ 1, a step occurs once every 2·P enabled `tick_en` cycles. P = 0 behaves like P = 1.
- R4: On each step, the accumulator adds the rate modulo 256.
- R5: While enabled, `level` shows the accumulator's bits 7:3 as they were just before the step's add. The value holds until the next step.
- R6: The step counter counts down through 7..1. A step that finds the counter at 1 has three effects:
  - `level` becomes 0.
  - The accumulator becomes the rate, because it is cleared and then the rate is added.
  - The counter reloads to 7.
- R7: While the channel is disabled:
  - The accumulator and the step counter hold.
  - `level` equals the accumulator's bits 7:3.
  - The prescaler and the timer are held at 0.

  After the channel is re-enabled, the first step comes on the second `tick_en`.
- R8: Cycles with `tick_en` low advance neither the prescaler, the timer nor the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Input clock enable driving the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| level | output | 5 | Channel output level |

## Verification
The bench builds the block with its default parameters:
- 8-bit accumulator
- 6-bit rate
- 12-bit period
- 5-bit output
- seven steps per cycle

Directed runs use periods 0, 1 and 2, which keep many steps short. This reaches several full seven-step cycles, accumulator wrap past 255 at rate 63, and disable/re-enable in mid-cycle. Random writes mixed with random `tick_en` then cover periods up to the full 12-bit range, although only low periods complete many steps.

// File: rtl/saw_pkg.sv
// Shared register addresses and field positions for the sawtooth channel.
// Assumes a 2-bit register address space.
package saw_pkg;
    localparam logic [1:0] ADDR_RATE = 2'd0;
    localparam logic [1:0] ADDR_PLO  = 2'd1;
    localparam logic [1:0] ADDR_PHI  = 2'd2;
    localparam int         EN_BIT    = 7;
endpackage

// File: rtl/saw_regs.sv
// Register file: captures rate, 12-bit period and enable from byte writes.
// Assumes PER_W is greater than 8 and at most 16 and RATE_W is at most 8.
module saw_regs
    import saw_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [RATE_W-1:0] rate,
    output logic [PER_W-1:0]  period,
    output logic              enable
);
    localparam int HI_W = PER_W - 8;

    // Decode a write and update the selected field on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate   <= '0;
            period <= '0;
            enable <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_RATE: rate <= wr_data[RATE_W-1:0];
                ADDR_PLO:  period[7:0] <= wr_data;
                ADDR_PHI: begin
                    period[PER_W-1:8] <= wr_data[HI_W-1:0];
                    enable            <= wr_data[EN_BIT];
                end
                default: ;
            endcase
        end
    end

    // R2
    wr_unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(rate) && $stable(period) && $stable(enable)));
endmodule

// File: rtl/saw_timer.sv
// Half-rate prescaler plus down-counting period timer; emits one step pulse
// per period of prescaled ticks. Assumes tick_en is a single-cycle enable.
module saw_timer #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enable,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    logic             presc;
    logic [PER_W-1:0] timer;
    logic             timer_done;

    // Timer expiry: a count of 0 or 1 ends the period.
    assign timer_done = (timer <= PER_W'(1));
    // Step fires on the second enabled tick when the timer expires.
    assign step = enable && tick_en && presc && timer_done;

    // Advance prescaler and timer; both are held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc <= 1'b0;
            timer <= '0;
        end else if (!enable) begin
            presc <= 1'b0;
            timer <= '0;
        end else if (tick_en) begin
            presc <= ~presc;
            if (presc)
                timer <= timer_done ? period : timer - PER_W'(1);
        end
    end

    // R3
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (timer == $past(period)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && enable) |=> ($stable(presc) && $stable(timer)));
endmodule

// File: rtl/saw_seq.sv
// Seven-step sequencer, wrapping accumulator and output truncation.
// Assumes step is a single-cycle pulse and STEPS fits the counter width.
module saw_seq #(
    parameter int ACC_W  = 8,
    parameter int RATE_W = 6,
    parameter int OUT_W  = 5,
    parameter int STEPS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    output logic [OUT_W-1:0]  level
);
    localparam int CNT_W = $clog2(STEPS + 1);

    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] acc;
    logic [OUT_W-1:0] out_q;
    logic [ACC_W-1:0] rate_ext;
    logic             wrap;

    assign rate_ext = {{(ACC_W-RATE_W){1'b0}}, rate};
    assign wrap     = (cnt == CNT_W'(1));

    // On each step: clear on the last count, else show and add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= CNT_W'(1);
            acc   <= '0;
            out_q <= '0;
        end else if (step) begin
            if (wrap) begin
                cnt   <= CNT_W'(STEPS);
                out_q <= '0;
                acc   <= rate_ext;
            end else begin
                cnt   <= cnt - CNT_W'(1);
                out_q <= acc[ACC_W-1 -: OUT_W];
                acc   <= acc + rate_ext;
            end
        end
    end

    // Output select: held step value when enabled, live accumulator otherwise.
    assign level = enable ? out_q : acc[ACC_W-1 -: OUT_W];

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(STEPS)));
    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap) |=> (out_q == '0 && cnt == CNT_W'(STEPS) && acc == $past(rate_ext)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(acc) && $stable(cnt)));
endmodule

// File: rtl/saw_channel.sv
// Top of the stepped sawtooth channel: registers, half-rate timer and
// seven-step accumulator sequencer. Assumes one write per clock at most.
module saw_channel #(
    parameter int ACC_W  = 8,
    parameter int RATE_W = 6,
    parameter int PER_W  = 12,
    parameter int OUT_W  = 5,
    parameter int STEPS  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic [OUT_W-1:0] level
);
    logic [RATE_W-1:0] rate;
    logic [PER_W-1:0]  period;
    logic              enable;
    logic              step;

    saw_regs #(.RATE_W(RATE_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate(rate), .period(period), .enable(enable)
    );

    saw_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enable(enable),
        .period(period), .step(step)
    );

    saw_seq #(.ACC_W(ACC_W), .RATE_W(RATE_W), .OUT_W(OUT_W), .STEPS(STEPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .enable(enable),
        .rate(rate), .level(level)
    );

    // R1
    reset_level_chk: assert property (@(posedge clk)
        !rst_n |=> (level == '0));
endmodule

// File: tb/sim_saw_channel.sv
// Bench for saw_channel: directed corners plus seeded random traffic,
// compared each cycle against a behavioural model built from the requirements.
module sim_saw_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    int m_rate, m_per, m_en, m_presc, m_timer, m_cnt, m_acc, m_out;

    always #4 clk = ~clk;

    saw_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .level(level)
    );

    function automatic int exp_level();
        return (m_en != 0) ? m_out : ((m_acc >> 3) & 31);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: level=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rate = 0; m_per = 0; m_en = 0; m_presc = 0;
        m_timer = 0; m_cnt = 1; m_acc = 0; m_out = 0;
    endtask

    // Model one clock edge: step logic uses old register values, then writes land.
    task automatic model_edge(input bit te, input bit we, input int a, input int d);
        bit stp;
        stp = 0;
        if (m_en == 0) begin
            m_presc = 0; m_timer = 0;
        end else if (te) begin
            if (m_presc != 0) begin
                if (m_timer <= 1) begin stp = 1; m_timer = m_per; end
                else m_timer = m_timer - 1;
            end
            m_presc = m_presc ^ 1;
        end
        if (stp) begin
            if (m_cnt == 1) begin m_cnt = 7; m_out = 0; m_acc = m_rate; end
            else begin
                m_cnt = m_cnt - 1;
                m_out = (m_acc >> 3) & 31;
                m_acc = (m_acc + m_rate) & 255;
            end
        end
        if (we) begin
            case (a)
                0: m_rate = d & 63;
                1: m_per = (m_per & 32'hF00) | d;
                2: begin m_per = (m_per & 255) | ((d & 15) << 8); m_en = (d >> 7) & 1; end
                default: ;
            endcase
        end
    endtask

    // One cycle: drive after the falling edge, compare at the next falling edge.
    task automatic cyc(input string req, input bit te, input bit we, input int a, input int d);
        tick_en = te; wr_en = we; wr_addr = a[1:0]; wr_data = d[7:0];
        @(posedge clk);
        model_edge(te, we, a, d);
        @(negedge clk);
        tick_en = 0; wr_en = 0;
        check(req, level, exp_level());
    endtask

    task automatic wr(input string req, input int a, input int d);
        cyc(req, 1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        int seen_zero;
        void'($urandom(32'd1357));
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", level, 0);

        // R2 / R1: rate 8, period 1, enable; first step clears.
        wr("R2", 0, 8'hC8);          // bits 7:6 ignored -> rate 8
        wr("R2", 1, 1);
        wr("R2", 2, 8'h80);
        ticks("R1", 2);
        check("R1", level, 0);
        // R6 / R5: full seven-step cycles 1..6 then 0.
        ticks("R6", 2 * 14);
        // R3: period 0 acts as period 1.
        wr("R3", 1, 0);
        ticks("R3", 10);
        // R3: period 2 -> step every 4 ticks; count ticks between changes.
        wr("R3", 1, 2);
        ticks("R3", 30);
        // R8: idle cycles do nothing.
        for (int i = 0; i < 8; i++) cyc("R8", 1'b0, 1'b0, 0, 0);
        // R4: rate 63 wraps past 255 across several cycles.
        wr("R4", 0, 63);
        wr("R4", 1, 1);
        ticks("R4", 40);
        // R7: disable mid-cycle, level shows accumulator, ticks ignored.
        wr("R7", 2, 8'h00);
        ticks("R7", 12);
        // R7: re-enable; first step on the second tick.
        wr("R7", 2, 8'h80);
        ticks("R7", 6);
        // R2: address 3 write has no effect.
        wr("R2", 3, 8'hFF);
        ticks("R2", 20);
        // R5: rate 8 sequence reaches zero output after a clear.
        wr("R5", 0, 8);
        seen_zero = 0;
        for (int i = 0; i < 40; i++) begin
            cyc("R5", 1'b1, 1'b0, 0, 0);
            if (level == 0) seen_zero++;
        end
        checks++;
        if (seen_zero == 0) begin
            fails++;
            $display("FAIL R6: zero level count=%0d expected>0", seen_zero);
        end

        // Random traffic, mostly short periods.
        for (int i = 0; i < 20000; i++) begin
            int r, a, d;
            r = $urandom_range(0, 99);
            if (r < 6) begin
                a = $urandom_range(0, 3);
                d = $urandom_range(0, 255);
                if (a == 1 && $urandom_range(0, 3) != 0) d = d & 3;
                if (a == 2 && $urandom_range(0, 3) != 0) d = (d & 8'h80) | ($urandom_range(0, 9) == 0 ? 1 : 0);
                if (a == 2 && $urandom_range(0, 4) != 0) d = d | 8'h80;
                cyc("R4", 1'b0, 1'b1, a, d);
            end else begin
                cyc("R5", (r < 80), 1'b0, 0, 0);
            end
        end

        // Reset mid-run returns to initial state.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1", level, 0);
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: cycles=150000 expected completion");
        finish_run();
    end
endmodule